// File: doc/BRIEF.md
# Codec Serial Port with Loop-Back Test Modes

This block is the device side of a synchronous serial link between a codec and a host processor. It runs on the system clock, makes the serial clock itself, and moves 16-bit words in both directions. A strobe at the sample rate starts an outgoing word that carries the current converter sample. Incoming words are either DAC samples or control words that update a small bank of configuration registers. The analog converters are modelled as parallel ports: `adc_data` is sampled on `smp_strobe`, and `dac_data` holds the DAC register.

Three test modes support bring-up. Digital loop-back copies each converter sample straight into the DAC register. Serial loop-back sends every received frame pulse and data bit back out exactly sixteen serial clocks later. An analog loop-back enable drives an analog switch, and it can only be turned on while the gain-tap amplifier is powered down. The two digital loop-back modes are sticky. A control write clears them only while mixed mode is already on. Otherwise only reset clears them.

Top module: `csp_top`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `sclk`, `sdo` and `sdofs` are 0, `dac_data` is 0, `ana_c`, `ana_d`, `ana_e` are 0 and `alb_en` is 0. All registers reset to 0.
- R2: A pulse on `smp_strobe` captures `adc_data`. On the next rising `sclk`, `sdofs` goes high for one serial clock. The word with its MSB forced to 0 then follows on `sdo`, MSB first, one bit per serial clock. Output bits change on the rising edge of `sclk`.
- R3: If a new strobe is pending while a word is being sent, `sdofs` is raised during the last bit of that word. The next word follows with no gap, so the two frame pulses are 16 serial clocks apart.
- R4: The serial clock period is 2^(s+1) system clocks, where s is bits 1:0 of register B. After reset s = 0.
- R5: `sdi` is sampled on the falling edge of `sclk`. A word starts on the sample after one where `sdifs` is 1. A received word with bit 15 = 0 is DAC data and is loaded into `dac_data`, unless digital loop-back is on.
- R6: A received word with bit 15 = 1 is a control write. Bits 14:12 select the register (0 to 5 = A to F) and bits 7:0 are the value. Register C drives `ana_c`, D drives `ana_d` and E drives `ana_e`. Selectors 6 and 7 change no register and do not change `dac_data`.
- R7: `alb_en` is bit 7 of register F. A write that would change that bit from 0 to 1 leaves it at 0 when bit 1 of register C is 1. Writing it to 0 always takes effect.
- R8: Bit 1 of register A enables digital loop-back. While it is set, each strobe copies all 16 bits of `adc_data` into `dac_data`, serial DAC words are ignored, and outgoing sample frames continue as in R2.
- R9: Bit 2 of register A enables serial loop-back. While it is set, `sdofs` and `sdo` repeat `sdifs` and `sdi` exactly 16 serial clocks later, and sample frames do not appear on the port.
- R10: A write to register A can clear bit 1 or bit 2 only if bit 0 of A (mixed mode) was already 1 before that write. Otherwise those bits keep their set state. A write can always set them, and bit 0 itself is always written as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_strobe | input | 1 | Sample-rate strobe, one system clock wide |
| adc_data | input | 16 | Converter sample, captured on the strobe |
| sdi | input | 1 | Serial data in |
| sdifs | input | 1 | Serial frame sync in |
| sclk | output | 1 | Serial clock generated by the block |
| sdo | output | 1 | Serial data out |
| sdofs | output | 1 | Serial frame sync out |
| dac_data | output | 16 | DAC register |
| ana_c | output | 8 | Register C (bit 1: gain-tap power) |
| ana_d | output | 8 | Register D |
| ana_e | output | 8 | Register E |
| alb_en | output | 1 | Analog loop-back switch enable |

## Verification
A wrong divider setting shows at once as a wrong `sclk` period. A fault in the transmitter shows within one frame as a wrong word or a shifted frame pulse at the serial output. A bad control register decode appears on the analog configuration outputs two serial clocks after the write. A sticky mode bit that is cleared when it should not be, or kept when it should be cleared, is caught on the next strobe or received DAC word: `dac_data` follows the wrong source. It is also caught on the next frame, which is echoed when it should not be, or not echoed when it should be.

// File: rtl/csp_pkg.sv
package csp_pkg;
   localparam int IDX_A = 0;
   localparam int IDX_B = 1;
   localparam int IDX_C = 2;
   localparam int IDX_D = 3;
   localparam int IDX_E = 4;
   localparam int IDX_F = 5;
   localparam int A_MM   = 0;
   localparam int A_DLB  = 1;
   localparam int A_SLB  = 2;
   localparam int C_GTAP = 1;
   localparam int F_ALB  = 7;
   localparam int MIN_REGS = 6;
endpackage

// File: rtl/csp_clkdiv.sv
module csp_clkdiv #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] sel,
   output logic             sclk,
   output logic             rise_tk,
   output logic             fall_tk
);
   localparam int CNT_W = (1 << SEL_W) - 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   half;
   logic [CNT_W-1:0] reload;
   logic             edge_now;

   always_comb begin
      half     = {{CNT_W{1'b0}}, 1'b1} << sel;
      reload   = CNT_W'(half - 1'b1);
      edge_now = (cnt == '0);
      rise_tk  = edge_now & ~sclk;
      fall_tk  = edge_now & sclk;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         sclk <= 1'b0;
      end else if (edge_now) begin
         sclk <= ~sclk;
         cnt  <= reload;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/csp_tx.sv
module csp_tx #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         rise_tk,
   input  logic         load,
   input  logic [W-1:0] word,
   output logic         sdo,
   output logic         sdofs
);
   localparam int BW = $clog2(W);

   logic         pend;
   logic [W-1:0] nxt;
   logic [W-1:0] hold;
   logic [W-1:0] sh;
   logic [BW-1:0] bidx;
   logic         act;
   logic         launch;

   always_comb begin
      launch = rise_tk && pend && !sdofs && (!act || bidx == BW'(W - 2));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend  <= 1'b0;
         nxt   <= '0;
         hold  <= '0;
         sh    <= '0;
         bidx  <= '0;
         act   <= 1'b0;
         sdo   <= 1'b0;
         sdofs <= 1'b0;
      end else begin
         if (rise_tk) begin
            if (sdofs) begin
               sdo   <= hold[W-1];
               sh    <= {hold[W-2:0], 1'b0};
               bidx  <= '0;
               act   <= 1'b1;
               sdofs <= 1'b0;
            end else if (act) begin
               if (bidx == BW'(W - 1)) begin
                  act <= 1'b0;
                  sdo <= 1'b0;
               end else begin
                  sdo  <= sh[W-1];
                  sh   <= {sh[W-2:0], 1'b0};
                  bidx <= bidx + 1'b1;
               end
            end
         end
         if (launch) begin
            sdofs <= 1'b1;
            hold  <= nxt;
            pend  <= 1'b0;
         end
         if (load) begin
            pend <= 1'b1;
            nxt  <= {1'b0, word[W-2:0]};
         end
      end
   end
endmodule

// File: rtl/csp_rx.sv
module csp_rx #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         fall_tk,
   input  logic         sdi,
   input  logic         sdifs,
   output logic [W-1:0] word,
   output logic         vld
);
   localparam int BW = $clog2(W + 1);

   logic          fs_d;
   logic          act;
   logic [BW-1:0] rcnt;
   logic [W-1:0]  rsh;

   always_ff @(posedge clk) begin
      if (rst) begin
         fs_d <= 1'b0;
         act  <= 1'b0;
         rcnt <= '0;
         rsh  <= '0;
         word <= '0;
         vld  <= 1'b0;
      end else begin
         vld <= 1'b0;
         if (fall_tk) begin
            fs_d <= sdifs;
            if (fs_d) begin
               rsh  <= {rsh[W-2:0], sdi};
               rcnt <= BW'(1);
               act  <= 1'b1;
            end else if (act) begin
               rsh  <= {rsh[W-2:0], sdi};
               rcnt <= rcnt + 1'b1;
               if (rcnt == BW'(W - 1)) begin
                  act  <= 1'b0;
                  word <= {rsh[W-2:0], sdi};
                  vld  <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/csp_echo.sv
module csp_echo #(
   parameter int DLY = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic rise_tk,
   input  logic fall_tk,
   input  logic sdi,
   input  logic sdifs,
   output logic e_sdo,
   output logic e_fs
);
   logic [DLY-1:0] line_d;
   logic [DLY-1:0] line_f;

   always_ff @(posedge clk) begin
      if (rst) begin
         line_d <= '0;
         line_f <= '0;
         e_sdo  <= 1'b0;
         e_fs   <= 1'b0;
      end else begin
         if (fall_tk) begin
            line_d <= {line_d[DLY-2:0], sdi};
            line_f <= {line_f[DLY-2:0], sdifs};
         end
         if (rise_tk) begin
            e_sdo <= line_d[DLY-1];
            e_fs  <= line_f[DLY-1];
         end
      end
   end
endmodule

// File: rtl/csp_ctrl.sv
module csp_ctrl
   import csp_pkg::*;
#(
   parameter int W    = 16,
   parameter int NREG = 6,
   parameter int AW   = 3,
   parameter int VW   = 8,
   parameter int DSW  = 2
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           rx_vld,
   input  logic [W-1:0]   rx_word,
   input  logic           smp_strobe,
   input  logic [W-1:0]   adc_data,
   output logic [W-1:0]   dac_data,
   output logic [DSW-1:0] div_sel,
   output logic           mm,
   output logic           dlb,
   output logic           slb,
   output logic           gtap,
   output logic           alb,
   output logic [VW-1:0]  ana_c,
   output logic [VW-1:0]  ana_d,
   output logic [VW-1:0]  ana_e
);
   logic [AW-1:0] wa;
   logic [VW-1:0] wv;
   logic          is_ctl;
   logic [VW-1:0] cr [NREG];
   logic [VW-1:0] nv [NREG];
   logic [NREG-1:0] hit;

   function automatic logic [VW-1:0] a_next(input logic [VW-1:0] v,
                                            input logic [VW-1:0] old);
      logic [VW-1:0] r;
      r = v;
      if (!old[A_MM]) begin
         r[A_DLB] = v[A_DLB] | old[A_DLB];
         r[A_SLB] = v[A_SLB] | old[A_SLB];
      end
      return r;
   endfunction

   function automatic logic [VW-1:0] f_next(input logic [VW-1:0] v,
                                            input logic [VW-1:0] old,
                                            input logic          tap_on);
      logic [VW-1:0] r;
      r = v;
      r[F_ALB] = v[F_ALB] & (old[F_ALB] | ~tap_on);
      return r;
   endfunction

   assign wa     = rx_word[W-2 -: AW];
   assign wv     = rx_word[VW-1:0];
   assign is_ctl = rx_vld & rx_word[W-1];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      assign hit[g] = is_ctl && (wa == AW'(g));
      if (g == IDX_A) begin : g_a
         assign nv[g] = a_next(wv, cr[g]);
      end else if (g == IDX_F) begin : g_f
         assign nv[g] = f_next(wv, cr[g], cr[IDX_C][C_GTAP]);
      end else begin : g_plain
         assign nv[g] = wv;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) cr[i] <= '0;
      end else begin
         for (int i = 0; i < NREG; i++) begin
            if (hit[i]) cr[i] <= nv[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dac_data <= '0;
      end else if (dlb) begin
         if (smp_strobe) dac_data <= adc_data;
      end else if (rx_vld && !rx_word[W-1]) begin
         dac_data <= rx_word;
      end
   end

   assign mm      = cr[IDX_A][A_MM];
   assign dlb     = cr[IDX_A][A_DLB];
   assign slb     = cr[IDX_A][A_SLB];
   assign div_sel = cr[IDX_B][DSW-1:0];
   assign gtap    = cr[IDX_C][C_GTAP];
   assign alb     = cr[IDX_F][F_ALB];
   assign ana_c   = cr[IDX_C];
   assign ana_d   = cr[IDX_D];
   assign ana_e   = cr[IDX_E];

   logic unused_cfg;
   always_comb begin
      unused_cfg = ^{cr[IDX_A][VW-1:A_SLB+1], cr[IDX_B][VW-1:DSW],
                     cr[IDX_F][F_ALB-1:0], rx_word[W-2-AW:VW]};
      for (int i = MIN_REGS; i < NREG; i++) unused_cfg = unused_cfg ^ (^cr[i]);
   end
endmodule

// File: rtl/csp_top.sv
module csp_top
   import csp_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int ADDR_W    = 3,
   parameter int VAL_W     = 8,
   parameter int NUM_REGS  = 6,
   parameter int DIV_SEL_W = 2,
   parameter bit ECHO_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              smp_strobe,
   input  logic [WORD_W-1:0] adc_data,
   input  logic              sdi,
   input  logic              sdifs,
   output logic              sclk,
   output logic              sdo,
   output logic              sdofs,
   output logic [WORD_W-1:0] dac_data,
   output logic [VAL_W-1:0]  ana_c,
   output logic [VAL_W-1:0]  ana_d,
   output logic [VAL_W-1:0]  ana_e,
   output logic              alb_en
);
   localparam int ECHO_DLY = WORD_W;

   if (WORD_W < ADDR_W + VAL_W + 2) begin : g_chk_word
      $error("csp_top: WORD_W too small for selector and value fields");
   end
   if (VAL_W < F_ALB + 1) begin : g_chk_val
      $error("csp_top: VAL_W must hold the loop-back enable bit");
   end
   if (NUM_REGS < MIN_REGS || NUM_REGS > (1 << ADDR_W)) begin : g_chk_regs
      $error("csp_top: NUM_REGS out of range");
   end
   if (DIV_SEL_W < 1 || DIV_SEL_W > 3 || DIV_SEL_W > VAL_W) begin : g_chk_div
      $error("csp_top: DIV_SEL_W out of range");
   end

   logic                 rise_tk, fall_tk;
   logic [DIV_SEL_W-1:0] div_sel;
   logic                 tx_sdo, tx_fs;
   logic                 e_sdo, e_fs;
   logic [WORD_W-1:0]    rx_word;
   logic                 rx_vld;
   logic                 mm, dlb, slb, gtap;

   csp_clkdiv #(.SEL_W(DIV_SEL_W)) u_div (
      .clk(clk), .rst(rst), .sel(div_sel),
      .sclk(sclk), .rise_tk(rise_tk), .fall_tk(fall_tk)
   );

   csp_tx #(.W(WORD_W)) u_tx (
      .clk(clk), .rst(rst), .rise_tk(rise_tk), .load(smp_strobe),
      .word(adc_data), .sdo(tx_sdo), .sdofs(tx_fs)
   );

   csp_rx #(.W(WORD_W)) u_rx (
      .clk(clk), .rst(rst), .fall_tk(fall_tk), .sdi(sdi), .sdifs(sdifs),
      .word(rx_word), .vld(rx_vld)
   );

   csp_ctrl #(.W(WORD_W), .NREG(NUM_REGS), .AW(ADDR_W), .VW(VAL_W),
              .DSW(DIV_SEL_W)) u_ctrl (
      .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_word(rx_word),
      .smp_strobe(smp_strobe), .adc_data(adc_data), .dac_data(dac_data),
      .div_sel(div_sel), .mm(mm), .dlb(dlb), .slb(slb), .gtap(gtap),
      .alb(alb_en), .ana_c(ana_c), .ana_d(ana_d), .ana_e(ana_e)
   );

   if (ECHO_EN) begin : g_echo
      csp_echo #(.DLY(ECHO_DLY)) u_echo (
         .clk(clk), .rst(rst), .rise_tk(rise_tk), .fall_tk(fall_tk),
         .sdi(sdi), .sdifs(sdifs), .e_sdo(e_sdo), .e_fs(e_fs)
      );
   end else begin : g_no_echo
      assign e_sdo = 1'b0;
      assign e_fs  = 1'b0;
   end

   assign sdo   = slb ? e_sdo : tx_sdo;
   assign sdofs = slb ? e_fs  : tx_fs;
endmodule

// File: rtl/csp_chk.sv
module csp_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst,
   input logic         rise_tk,
   input logic         sdo,
   input logic         sdofs,
   input logic         mm,
   input logic         dlb,
   input logic         slb,
   input logic         gtap,
   input logic         alb_en,
   input logic         smp_strobe,
   input logic [W-1:0] adc_data,
   input logic [W-1:0] dac_data
);
   a_r2_first_bit_zero: assert property (@(posedge clk) disable iff (rst)
      (rise_tk && sdofs && !slb) |=> (slb || !sdo));

   a_r3_fs_single: assert property (@(posedge clk) disable iff (rst)
      (rise_tk && sdofs && !slb) |=> (slb || !sdofs));

   a_r7_alb_interlock: assert property (@(posedge clk) disable iff (rst)
      $rose(alb_en) |-> !$past(gtap));

   a_r8_dlb_copy: assert property (@(posedge clk) disable iff (rst)
      (dlb && smp_strobe) |=> (dac_data == $past(adc_data)));

   a_r10_dlb_sticky: assert property (@(posedge clk) disable iff (rst)
      $fell(dlb) |-> $past(mm));

   a_r10_slb_sticky: assert property (@(posedge clk) disable iff (rst)
      $fell(slb) |-> $past(mm));
endmodule

bind csp_top csp_chk #(.W(WORD_W)) u_chk (
   .clk(clk), .rst(rst), .rise_tk(rise_tk), .sdo(sdo), .sdofs(sdofs),
   .mm(mm), .dlb(dlb), .slb(slb), .gtap(gtap), .alb_en(alb_en),
   .smp_strobe(smp_strobe), .adc_data(adc_data), .dac_data(dac_data)
);

// File: tb/csp_top_tb.sv
module csp_top_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        smp_strobe = 1'b0;
   logic [15:0] adc_data = '0;
   logic        sdi = 1'b0;
   logic        sdifs = 1'b0;
   logic        sclk, sdo, sdofs, alb_en;
   logic [15:0] dac_data;
   logic [7:0]  ana_c, ana_d, ana_e;

   csp_top u_dut (
      .clk(clk), .rst(rst), .smp_strobe(smp_strobe), .adc_data(adc_data),
      .sdi(sdi), .sdifs(sdifs), .sclk(sclk), .sdo(sdo), .sdofs(sdofs),
      .dac_data(dac_data), .ana_c(ana_c), .ana_d(ana_d), .ana_e(ana_e),
      .alb_en(alb_en)
   );

   always #4 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", r, act, exp);
      end
   endtask

   task automatic expect_word(input logic [15:0] w, input string t);
      exp_q.push_back(w);
      tag_q.push_back(t);
   endtask

   // scoreboard monitor: decodes frames on the output port at falling sclk
   int fall_n = 0, in_fs_at = -100, out_fs_at = -100, out_fs_prev = -100;
   logic m_fsd = 1'b0, m_act = 1'b0;
   int m_cnt = 0;
   logic [15:0] m_sh = '0;
   always @(negedge sclk) begin
      fall_n++;
      if (sdifs) in_fs_at = fall_n;
      if (m_fsd) begin
         m_sh = {m_sh[14:0], sdo}; m_cnt = 1; m_act = 1'b1;
      end else if (m_act) begin
         m_sh = {m_sh[14:0], sdo}; m_cnt++;
         if (m_cnt == 16) begin
            m_act = 1'b0;
            if (exp_q.size() == 0) begin
               n_chk++; n_bad++;
               $display("FAIL R2 unexpected frame: actual %0h expected none", m_sh);
            end else begin
               automatic logic [15:0] e = exp_q.pop_front();
               automatic string t = tag_q.pop_front();
               chk(t, m_sh, e);
            end
         end
      end
      if (sdofs) begin out_fs_prev = out_fs_at; out_fs_at = fall_n; end
      m_fsd = sdofs;
   end

   task automatic wait_sclk(input int n);
      repeat (n) @(posedge sclk);
      #1;
   endtask

   task automatic send_word(input logic [15:0] w);
      @(posedge sclk); #1 sdifs = 1'b1;
      for (int i = 15; i >= 0; i--) begin
         @(posedge sclk); #1 sdifs = 1'b0; sdi = w[i];
      end
      @(posedge sclk); #1 sdi = 1'b0;
   endtask

   task automatic ctl(input logic [2:0] a, input logic [7:0] v);
      send_word({1'b1, a, 4'b0000, v});
      wait_sclk(2);
   endtask

   task automatic strobe(input logic [15:0] d);
      @(negedge clk); adc_data = d; smp_strobe = 1'b1;
      @(negedge clk); smp_strobe = 1'b0;
   endtask

   task automatic measure(input logic [31:0] exp);
      int n;
      logic prev;
      @(posedge sclk); #1;
      prev = 1'b1; n = 0;
      while (1) begin
         @(negedge clk); n++;
         if (sclk && !prev) break;
         prev = sclk;
      end
      chk("R4 sclk period", n - 1, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1 sclk", sclk, 0);
      chk("R1 sdofs", sdofs, 0);
      chk("R1 sdo", sdo, 0);
      chk("R1 dac", dac_data, 0);
      chk("R1 ana_c", ana_c, 0);
      chk("R1 alb", alb_en, 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 sdofs after release", sdofs, 0);
      chk("R1 dac after release", dac_data, 0);

      // R4 default divide
      measure(2);

      // R2 sample frames, MSB forced low
      expect_word(16'h7FFF, "R2 frame ffff");
      strobe(16'hFFFF);
      wait_sclk(20);
      expect_word(16'h1234, "R2 frame 1234");
      strobe(16'h1234);
      wait_sclk(20);
      chk("R2 all frames seen", exp_q.size(), 0);

      // R3 back-to-back frames
      expect_word(16'h0A5A, "R3 first word");
      expect_word(16'h7001, "R3 second word");
      strobe(16'h0A5A);
      @(posedge sdofs);
      wait_sclk(5);
      strobe(16'hF001);
      wait_sclk(40);
      chk("R3 fs spacing", out_fs_at - out_fs_prev, 16);

      // R5 serial DAC data
      send_word(16'h2BCD);
      wait_sclk(2);
      chk("R5 dac load", dac_data, 16'h2BCD);

      // R6 control writes and unused selectors
      ctl(3'd3, 8'h5A);
      chk("R6 reg D", ana_d, 8'h5A);
      ctl(3'd4, 8'hC3);
      chk("R6 reg E", ana_e, 8'hC3);
      ctl(3'd6, 8'hFF);
      ctl(3'd7, 8'hFF);
      chk("R6 sel 6/7 C", ana_c, 8'h00);
      chk("R6 sel 6/7 D", ana_d, 8'h5A);
      chk("R6 sel 6/7 E", ana_e, 8'hC3);
      chk("R6 sel 6/7 dac", dac_data, 16'h2BCD);
      chk("R6 sel 6/7 alb", alb_en, 0);

      // R4 divider settings
      ctl(3'd1, 8'h03);
      wait_sclk(3);
      measure(16);
      ctl(3'd1, 8'h01);
      wait_sclk(3);
      measure(4);
      expect_word(16'h4321, "R4 frame at div4");
      strobe(16'h4321);
      wait_sclk(20);
      ctl(3'd1, 8'h00);
      wait_sclk(3);

      // R7 analog loop-back interlock
      ctl(3'd2, 8'h02);
      chk("R7 reg C", ana_c, 8'h02);
      ctl(3'd5, 8'h80);
      chk("R7 blocked by tap", alb_en, 0);
      ctl(3'd2, 8'h00);
      ctl(3'd5, 8'h80);
      chk("R7 enabled", alb_en, 1);
      ctl(3'd5, 8'h00);
      chk("R7 cleared", alb_en, 0);

      // R8 digital loop-back
      ctl(3'd0, 8'h02);
      expect_word(16'h6666, "R8 frame in dlb");
      strobe(16'hE666);
      wait_sclk(20);
      chk("R8 dac copy", dac_data, 16'hE666);
      send_word(16'h0111);
      wait_sclk(2);
      chk("R8 serial dac ignored", dac_data, 16'hE666);

      // R10 sticky clear rules
      ctl(3'd0, 8'h00);
      expect_word(16'h1357, "R10 frame");
      strobe(16'h1357);
      wait_sclk(20);
      chk("R10 dlb kept without mm", dac_data, 16'h1357);
      ctl(3'd0, 8'h01);
      expect_word(16'h2468, "R10 frame");
      strobe(16'h2468);
      wait_sclk(20);
      chk("R10 dlb kept when mm set by same write", dac_data, 16'h2468);
      ctl(3'd0, 8'h01);
      expect_word(16'h0F0F, "R10 frame");
      strobe(16'h0F0F);
      wait_sclk(20);
      chk("R10 dlb cleared under mm", dac_data, 16'h2468);
      send_word(16'h0222);
      wait_sclk(2);
      chk("R10 serial dac resumes", dac_data, 16'h0222);

      // R9 serial loop-back
      ctl(3'd0, 8'h05);
      expect_word(16'h3C5A, "R9 echo word");
      send_word(16'h3C5A);
      wait_sclk(20);
      chk("R9 echo delay", out_fs_at - in_fs_at, 16);
      strobe(16'h1111);
      wait_sclk(25);
      chk("R9 sample frame suppressed", exp_q.size(), 0);
      // the clearing write's own frame pulse is echoed, then the idle port follows
      expect_word(16'h0000, "R9 echo of clearing write");
      ctl(3'd0, 8'h01);
      wait_sclk(20);
      expect_word(16'h0ABC, "R9 frames resume");
      strobe(16'h0ABC);
      wait_sclk(22);
      chk("R9 all frames seen", exp_q.size(), 0);

      finish_run();
   end
endmodule